// File: doc/BRIEF.md
# Bit-Slice ALU with Adder-Driven Rotate

This block is a 16-bit arithmetic and logic unit made from one identical single-bit cell repeated across the word. A ripple carry joins the cells. It performs bitwise AND, bitwise OR, addition and subtraction. It also performs three single-position left moves: shift, rotate, and rotate through the carry flag. The datapath has no separate shifter. For the three left moves, both adder inputs of every cell take operand A, so the adder produces A doubled. The only difference between the three moves is the bit that enters the carry chain at position 0.

The result, carry-out and zero flag are combinational. A one-bit carry flag register captures the carry-out on a clock edge when its enable is high. This lets the next rotate-through-carry pick up the bit that was pushed out, so a chain of such rotates forms a 17-bit rotation across the word and the flag. The surrounding pipeline chooses the opcode and decides when the flag is written.

Top module: `slice_alu16`

## Requirements
- R1: Opcode 000 gives `a & b` and opcode 001 gives `a | b`. For both, `cout` is 0.
- R2: Opcode 010 gives `a + b` modulo 2^16. `cout` is the 17th sum bit.
- R3: Opcode 011 gives `a - b` modulo 2^16. `cout` is 1 exactly when `a >= b` as unsigned values, which means no borrow.
- R4: Opcode 100 gives `{a[14:0], 1'b0}` with `cout = a[15]`.
- R5: Opcode 101 gives `{a[14:0], a[15]}` with `cout = a[15]`.
- R6: Opcode 110 gives `{a[14:0], carry_q}` with `cout = a[15]`.
- R7: Opcode 111 gives a result of 0 and `cout` of 0. It leaves `carry_q` unchanged even when `flag_en` is high.
- R8: `zero` is 1 exactly when all 16 result bits are 0, for every opcode.
- R9: On a rising clock edge, `rst` high clears `carry_q` to 0. Otherwise, `flag_en` high with an opcode other than 111 loads `cout`, and any other case holds `carry_q`.
- R10: For opcodes 100, 101 and 110, operand `b` has no effect on `result` or `cout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the carry flag register |
| rst | input | 1 | Synchronous reset, active high, clears the flag |
| flag_en | input | 1 | Lets the flag register capture `cout` |
| a | input | 16 | Operand A, also the source for shift and rotate |
| b | input | 16 | Operand B |
| op | input | 3 | Operation code |
| result | output | 16 | Combinational result |
| cout | output | 1 | Carry-out of the operation |
| zero | output | 1 | High when the result is all zeros |
| carry_q | output | 1 | Stored carry flag |

## Verification
Each opcode is tried on the words 0x0000, 0xFFFF and 0x8000. The 0x8000 word has only the top bit set, so it shows whether that bit reaches bit 0, reaches only `cout`, or is lost. That single case separates shift, rotate and rotate-through-carry. Each of these words is run with the stored flag at 0 and again at 1, which shows that only the through-carry rotate reads the flag. Random operands then test the carry chain across all 16 cells in add and subtract, and a chain of back-to-back through-carry rotates tests the 17-bit cycle. Repeating the same A with different B values confirms that the left moves ignore B.

// File: rtl/slice_alu16.sv
module slice_alu16 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flag_en,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  output logic [W-1:0] result,
  output logic         cout,
  output logic         zero,
  output logic         carry_q
);
  localparam logic [2:0] OP_AND = 3'd0;
  localparam logic [2:0] OP_OR  = 3'd1;
  localparam logic [2:0] OP_ADD = 3'd2;
  localparam logic [2:0] OP_SUB = 3'd3;
  localparam logic [2:0] OP_SHL = 3'd4;
  localparam logic [2:0] OP_ROL = 3'd5;
  localparam logic [2:0] OP_RCL = 3'd6;

  logic dbl, inv_b, arith;
  logic [W:0] c;

  assign dbl   = (op == OP_SHL) || (op == OP_ROL) || (op == OP_RCL);
  assign inv_b = (op == OP_SUB);
  assign arith = dbl || (op == OP_ADD) || inv_b;

  always_comb begin
    case (op)
      OP_SUB:  c[0] = 1'b1;
      OP_ROL:  c[0] = a[W-1];
      OP_RCL:  c[0] = carry_q;
      default: c[0] = 1'b0;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic y, s;
    assign y = dbl ? a[i] : (b[i] ^ inv_b);
    assign s = a[i] ^ y ^ c[i];
    assign c[i+1] = (a[i] & y) | (c[i] & (a[i] ^ y));
    assign result[i] = (op == OP_AND) ? (a[i] & b[i]) :
                       (op == OP_OR)  ? (a[i] | b[i]) :
                       arith          ? s : 1'b0;
  end

  assign cout = arith & c[W];
  assign zero = ~|result;

  always_ff @(posedge clk) begin
    if (rst)
      carry_q <= 1'b0;
    else if (flag_en && op != 3'd7)
      carry_q <= cout;
  end
endmodule

// File: rtl/slice_alu16_chk.sv
module slice_alu16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         flag_en,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [2:0]   op,
  input logic [W-1:0] result,
  input logic         cout,
  input logic         zero,
  input logic         carry_q
);
  p_logic_nocarry_r1: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd0 || op == 3'd1) |-> !cout);

  p_sub_noborrow_r3: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd3 && a >= b) |-> cout);

  p_shl_lsb_r4: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd4) |-> (!result[0] && cout == a[W-1]));

  p_rol_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd5) |-> (result[0] == a[W-1] && cout == a[W-1]));

  p_rcl_in_r6: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd6) |-> (result[0] == carry_q && cout == a[W-1]));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd7) |=> (carry_q == $past(carry_q)));

  p_flag_load_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_en && op != 3'd7) |=> (carry_q == $past(cout)));

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !flag_en |=> $stable(carry_q));
endmodule

bind slice_alu16 slice_alu16_chk #(.W(W)) u_chk (.*);

// File: tb/slice_alu16_test.sv
module slice_alu16_test;
  logic clk = 0, rst = 1, flag_en = 0;
  logic [15:0] a = 0, b = 0;
  logic [2:0] op = 0;
  logic [15:0] result;
  logic cout, zero, carry_q;

  always #5 clk = ~clk;

  slice_alu16 uut (.clk, .rst, .flag_en, .a, .b, .op, .result, .cout, .zero, .carry_q);

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] res;
    logic        co;
    logic        z;
    logic        fl;
  } item_t;

  item_t sb[$];
  int total = 0, bad = 0;
  logic mflag = 0;

  function automatic string req_of(logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string rq, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s op result/flag: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // driver: applies stimulus, pushes expected item, advances model flag
  task automatic drive(logic [2:0] o, logic [15:0] x, logic [15:0] y, logic en, logic r);
    item_t it;
    logic [16:0] s;
    @(negedge clk);
    op = o; a = x; b = y; flag_en = en; rst = r;
    it.op = o; it.fl = mflag;
    case (o)
      3'd0: s = {1'b0, x & y};
      3'd1: s = {1'b0, x | y};
      3'd2: s = {1'b0, x} + {1'b0, y};
      3'd3: s = {1'b0, x} + {1'b0, ~y} + 17'd1;
      3'd4: s = {x, 1'b0};
      3'd5: s = {x, x[15]};
      3'd6: s = {x, mflag};
      default: s = 17'd0;
    endcase
    it.res = s[15:0]; it.co = s[16]; it.z = (s[15:0] == 16'd0);
    sb.push_back(it);
    if (r) mflag = 1'b0;
    else if (en && o != 3'd7) mflag = s[16];
  endtask

  // monitor: compares mid-cycle
  initial forever begin
    @(negedge clk);
    #2;
    if (sb.size() > 0 && !rst) begin
      item_t e;
      e = sb.pop_front();
      chk(req_of(e.op), result, e.res);
      chk(req_of(e.op), {15'd0, cout}, {15'd0, e.co});
      chk("R8", {15'd0, zero}, {15'd0, e.z});
      chk("R9", {15'd0, carry_q}, {15'd0, e.fl});
    end else if (sb.size() > 0) begin
      void'(sb.pop_front());
    end
  end

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [15:0] corner [3] = '{16'h0000, 16'hFFFF, 16'h8000};

  initial begin
    drive(3'd2, 16'h8000, 16'h8000, 1, 1);
    drive(3'd2, 16'h8000, 16'h8000, 1, 1);
    // R9 reset state: flag reads 0 after reset
    drive(3'd0, 16'h0000, 16'h0000, 0, 0);
    for (int f = 0; f < 2; f++) begin
      drive(3'd5, f ? 16'h8000 : 16'h0000, 16'h0, 1, 0);
      for (int o = 0; o < 8; o++)
        for (int i = 0; i < 3; i++)
          for (int j = 0; j < 3; j++)
            drive(3'(o), corner[i], corner[j], 0, 0);
    end
    // R10: same A, different B for the left moves
    for (int o = 4; o < 7; o++) begin
      drive(3'(o), 16'hC3A5, 16'h0000, 0, 0);
      drive(3'(o), 16'hC3A5, 16'hFFFF, 0, 0);
      drive(3'(o), 16'hC3A5, 16'h5A5A, 0, 0);
    end
    // R6: chained 17-bit rotate through carry
    drive(3'd6, 16'h8001, 16'h0, 1, 0);
    for (int k = 0; k < 20; k++) drive(3'd6, 16'(k * 16'h1357), 16'h0, 1, 0);
    // R7: idle opcode keeps flag with enable high
    drive(3'd2, 16'hFFFF, 16'h0001, 1, 0);
    drive(3'd7, 16'h1234, 16'h4321, 1, 0);
    drive(3'd6, 16'h0000, 16'h0000, 0, 0);
    // R9: hold without enable, then synchronous clear
    drive(3'd5, 16'h0001, 16'h0, 0, 0);
    drive(3'd6, 16'h0000, 16'h0, 0, 0);
    drive(3'd2, 16'hFFFF, 16'hFFFF, 1, 0);
    drive(3'd2, 16'h0000, 16'h0000, 1, 1);
    drive(3'd6, 16'h0000, 16'h0000, 0, 0);
    for (int k = 0; k < 320; k++)
      drive(3'(k % 8), 16'($urandom), 16'($urandom), 1'($urandom), 0);
    drive(3'd0, 16'h0, 16'h0, 0, 0);
    @(negedge clk); @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule